// File: doc/BRIEF.md
# Timed Configuration and Signature Read Unit

This block sits beside a small CPU's program-memory read port and decides what a program-memory load returns. Software writes a three-bit control register to arm one of two modes: configuration-read, which exposes the fuse and lock settings, or signature-read, which exposes the device identity bytes and the oscillator calibration byte. Once a mode is armed, a short window opens. The first load inside that window is redirected to a small space decoded from the 16-bit load pointer. The load then returns the selected configuration or signature byte instead of program memory. The arm bits clear themselves when that load completes, when the window runs out, or, in configuration-read mode, when a store-program-memory strobe arrives.

All fuse, lock, signature and calibration values are static input ports. A programmed bit is presented and read back as 0, and an unprogrammed bit as 1. Loads, stores and register writes are single-cycle strobes. Each load produces exactly one registered response pulse on the next cycle. The response has no back-pressure: the CPU side always accepts it, so the unit has no ready signal and keeps no holding buffer.

Top module: `cfgrd_unit`

## Requirements
- R1: Every cycle with `ld_strobe` high is followed, on the next cycle, by exactly one cycle of `ld_valid` high. `ld_valid` is low in all other cycles, and no back-pressure is applied.
- R2: With no mode armed (`ctl_q` = 3'b000), the response data equals the `pmem_rdata` value sampled with the load.
- R3: In configuration-read mode, pointer 0x0000 returns `fuse_lo_i` and pointer 0x0003 returns `fuse_hi_i`, bit for bit. A programmed bit reads as 0 and an unprogrammed bit as 1.
- R4: In configuration-read mode, pointer 0x0002 returns {5'b11111, `fuse_ext_i`[2:0]} and pointer 0x0001 returns {2'b11, `lock_i`[5:0]}. In `lock_i`, bits 5:2 are the boot-lock bits and bits 1:0 are the lock bits.
- R5: In signature-read mode, pointers 0x0000, 0x0002 and 0x0004 return signature bytes 1, 2 and 3 respectively, and pointer 0x0001 returns `osc_cal_i`.
- R6: In either armed mode, any pointer not listed in R3 to R5 returns 0xFF.
- R7: Only a load sampled on the 1st, 2nd or 3rd clock edge after the arming write is redirected. If none arrives, the mode disarms on the 3rd edge, and later loads return program memory.
- R8: A redirected load disarms the mode, so the following load returns program memory.
- R9: In configuration-read mode, a `spm_strobe` pulse disarms the mode at once, with no response.
- R10: Every control write restarts the window. A write with the enable bit (bit 0) low disarms the unit.
- R11: Control bits: bit 0 enables, bit 1 selects configuration-read, bit 2 selects signature-read. When both mode bits are written with enable, signature-read wins and `ctl_q` reads 3'b101. Configuration-read reads 3'b011.
- R12: Reset clears `ctl_q`, `ld_valid` and `ld_data` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 3 | Control write value {sig, cfg, en} |
| ctl_q | output | 3 | Current control bits {sig, cfg, en} |
| spm_strobe | input | 1 | Store-program-memory instruction strobe |
| ld_strobe | input | 1 | Program-memory load strobe |
| ld_ptr | input | 16 | Load address pointer |
| pmem_rdata | input | 8 | Normal program-memory data for this load |
| ld_valid | output | 1 | Response pulse, one cycle after a load |
| ld_data | output | 8 | Response byte |
| fuse_lo_i | input | 8 | Fuse low byte |
| fuse_hi_i | input | 8 | Fuse high byte |
| fuse_ext_i | input | 3 | Extended fuse bits |
| lock_i | input | 6 | Boot-lock bits [5:2] and lock bits [1:0] |
| sig_byte1_i | input | 8 | Device signature byte 1 |
| sig_byte2_i | input | 8 | Device signature byte 2 |
| sig_byte3_i | input | 8 | Device signature byte 3 |
| osc_cal_i | input | 8 | Oscillator calibration byte |

## Verification
The assertions assume that the fuse, lock, signature and calibration inputs stay constant while a redirected load is in flight. They also assume that strobes are clean single-cycle levels sampled at the clock edge, and that the window counter never needs to exceed its limit. The stimulus therefore sets the static values once before reset is released. It changes strobes only on the falling edge and lets each load last one cycle. It also places loads, stores and rewrites at chosen offsets inside and just beyond the three-edge window.

// File: rtl/cfgrd_pkg.sv
package cfgrd_pkg;
  typedef enum logic [1:0] {
    MODE_IDLE = 2'd0,
    MODE_CFG  = 2'd1,
    MODE_SIG  = 2'd2
  } rd_mode_e;

  localparam int CTL_W   = 3;
  localparam int CTL_EN  = 0;
  localparam int CTL_CFG = 1;
  localparam int CTL_SIG = 2;
endpackage

// File: rtl/cfgrd_arm.sv
module cfgrd_arm
  import cfgrd_pkg::*;
#(
  parameter int WINDOW = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_we,
  input  logic [CTL_W-1:0] ctl_wdata,
  input  logic             load_i,
  input  logic             spm_i,
  output rd_mode_e         mode_o,
  output logic [CTL_W-1:0] ctl_q
);
  localparam int CNT_W = $clog2(WINDOW + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WINDOW - 1);

  rd_mode_e         mode_q, mode_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    mode_d = mode_q;
    cnt_d  = cnt_q;
    if (ctl_we) begin
      cnt_d = '0;
      if (ctl_wdata[CTL_EN] && ctl_wdata[CTL_SIG])      mode_d = MODE_SIG;
      else if (ctl_wdata[CTL_EN] && ctl_wdata[CTL_CFG]) mode_d = MODE_CFG;
      else                                              mode_d = MODE_IDLE;
    end else if (mode_q != MODE_IDLE) begin
      if (load_i)                           mode_d = MODE_IDLE;
      else if (spm_i && mode_q == MODE_CFG) mode_d = MODE_IDLE;
      else if (cnt_q == LAST)               mode_d = MODE_IDLE;
      else                                  cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_IDLE;
      cnt_q  <= '0;
    end else begin
      mode_q <= mode_d;
      cnt_q  <= cnt_d;
    end
  end

  assign mode_o = mode_q;

  always_comb begin
    ctl_q = '0;
    case (mode_q)
      MODE_CFG: begin ctl_q[CTL_EN] = 1'b1; ctl_q[CTL_CFG] = 1'b1; end
      MODE_SIG: begin ctl_q[CTL_EN] = 1'b1; ctl_q[CTL_SIG] = 1'b1; end
      default:  ctl_q = '0;
    endcase
  end

  AST_WINDOW_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q != MODE_IDLE) |-> (cnt_q <= LAST)) else $error("window counter overrun"); // R7

  AST_EXPIRE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q != MODE_IDLE && cnt_q == LAST && !ctl_we) |=> (mode_q == MODE_IDLE)) else $error("window did not expire"); // R7

  AST_USE_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q != MODE_IDLE && load_i && !ctl_we) |=> (mode_q == MODE_IDLE)) else $error("arm kept after use"); // R8

  AST_STORE_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_CFG && spm_i && !ctl_we) |=> (ctl_q == '0)) else $error("store did not disarm"); // R9

  AST_SIG_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_we && ctl_wdata[CTL_EN] && ctl_wdata[CTL_SIG]) |=> (ctl_q == 3'b101)) else $error("signature priority lost"); // R11
endmodule

// File: rtl/cfgrd_space.sv
module cfgrd_space
  import cfgrd_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  rd_mode_e          mode_i,
  input  logic [ADDR_W-1:0] ptr_i,
  input  logic [DATA_W-1:0] pmem_i,
  input  logic [DATA_W-1:0] fuse_lo_i,
  input  logic [DATA_W-1:0] fuse_hi_i,
  input  logic [2:0]        fuse_ext_i,
  input  logic [5:0]        lock_i,
  input  logic [DATA_W-1:0] sig1_i,
  input  logic [DATA_W-1:0] sig2_i,
  input  logic [DATA_W-1:0] sig3_i,
  input  logic [DATA_W-1:0] cal_i,
  output logic [DATA_W-1:0] data_o
);
  localparam logic [DATA_W-1:0] ALL_ONES = '1;

  logic [DATA_W-1:0] cfg_byte, sig_byte, ext_byte, lock_byte;

  assign ext_byte  = {{(DATA_W-3){1'b1}}, fuse_ext_i};
  assign lock_byte = {{(DATA_W-6){1'b1}}, lock_i};

  always_comb begin
    case (ptr_i)
      ADDR_W'(0): cfg_byte = fuse_lo_i;
      ADDR_W'(1): cfg_byte = lock_byte;
      ADDR_W'(2): cfg_byte = ext_byte;
      ADDR_W'(3): cfg_byte = fuse_hi_i;
      default:    cfg_byte = ALL_ONES;
    endcase
  end

  always_comb begin
    case (ptr_i)
      ADDR_W'(0): sig_byte = sig1_i;
      ADDR_W'(1): sig_byte = cal_i;
      ADDR_W'(2): sig_byte = sig2_i;
      ADDR_W'(4): sig_byte = sig3_i;
      default:    sig_byte = ALL_ONES;
    endcase
  end

  always_comb begin
    case (mode_i)
      MODE_CFG: data_o = cfg_byte;
      MODE_SIG: data_o = sig_byte;
      default:  data_o = pmem_i;
    endcase
  end
endmodule

// File: rtl/cfgrd_unit.sv
module cfgrd_unit
  import cfgrd_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int WINDOW = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_we,
  input  logic [2:0]        ctl_wdata,
  output logic [2:0]        ctl_q,
  input  logic              spm_strobe,
  input  logic              ld_strobe,
  input  logic [ADDR_W-1:0] ld_ptr,
  input  logic [DATA_W-1:0] pmem_rdata,
  output logic              ld_valid,
  output logic [DATA_W-1:0] ld_data,
  input  logic [DATA_W-1:0] fuse_lo_i,
  input  logic [DATA_W-1:0] fuse_hi_i,
  input  logic [2:0]        fuse_ext_i,
  input  logic [5:0]        lock_i,
  input  logic [DATA_W-1:0] sig_byte1_i,
  input  logic [DATA_W-1:0] sig_byte2_i,
  input  logic [DATA_W-1:0] sig_byte3_i,
  input  logic [DATA_W-1:0] osc_cal_i
);
  rd_mode_e          mode;
  logic [DATA_W-1:0] sel_data;

  cfgrd_arm #(.WINDOW(WINDOW)) u_arm (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .load_i(ld_strobe), .spm_i(spm_strobe), .mode_o(mode), .ctl_q(ctl_q)
  );

  cfgrd_space #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_space (
    .mode_i(mode), .ptr_i(ld_ptr), .pmem_i(pmem_rdata),
    .fuse_lo_i(fuse_lo_i), .fuse_hi_i(fuse_hi_i), .fuse_ext_i(fuse_ext_i),
    .lock_i(lock_i), .sig1_i(sig_byte1_i), .sig2_i(sig_byte2_i),
    .sig3_i(sig_byte3_i), .cal_i(osc_cal_i), .data_o(sel_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ld_valid <= 1'b0;
      ld_data  <= '0;
    end else begin
      ld_valid <= ld_strobe;
      if (ld_strobe) ld_data <= sel_data;
    end
  end

  AST_RESP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    ld_strobe |=> ld_valid) else $error("missing response"); // R1

  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_strobe |=> !ld_valid) else $error("spurious response"); // R1

  AST_IDLE_PASSTHRU: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_strobe && mode == MODE_IDLE) |=> (ld_data == $past(pmem_rdata))) else $error("idle load altered"); // R2

  AST_UNLISTED_FF: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_strobe && mode != MODE_IDLE && ld_ptr > ADDR_W'(4)) |=> (ld_data == '1)) else $error("unlisted pointer"); // R6
endmodule

// File: tb/tb_cfgrd_unit.sv
`timescale 1ns/1ps
module tb_cfgrd_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctl_we = 1'b0;
  logic [2:0]  ctl_wdata = '0;
  logic [2:0]  ctl_q;
  logic        spm_strobe = 1'b0;
  logic        ld_strobe = 1'b0;
  logic [15:0] ld_ptr = '0;
  logic [7:0]  pmem_rdata = '0;
  logic        ld_valid;
  logic [7:0]  ld_data;
  logic [7:0]  fuse_lo = 8'h62, fuse_hi = 8'hD9, sig1 = 8'h1E, sig2 = 8'h94, sig3 = 8'h82, cal = 8'h5A;
  logic [2:0]  fuse_ext = 3'b100;
  logic [5:0]  lock = 6'b101100;

  int checks = 0, fails = 0;
  int m_mode = 0, m_cnt = 0;
  logic       e_valid = 1'b0;
  logic [7:0] e_data = '0;

  always #5 clk = ~clk;

  cfgrd_unit dut (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .ctl_q(ctl_q),
    .spm_strobe(spm_strobe), .ld_strobe(ld_strobe), .ld_ptr(ld_ptr), .pmem_rdata(pmem_rdata),
    .ld_valid(ld_valid), .ld_data(ld_data), .fuse_lo_i(fuse_lo), .fuse_hi_i(fuse_hi),
    .fuse_ext_i(fuse_ext), .lock_i(lock), .sig_byte1_i(sig1), .sig_byte2_i(sig2),
    .sig_byte3_i(sig3), .osc_cal_i(cal)
  );

  function automatic logic [7:0] ref_byte(int mode, logic [15:0] p, logic [7:0] pm);
    if (mode == 1) begin
      if (p == 0) return fuse_lo;
      if (p == 1) return {2'b11, lock};
      if (p == 2) return {5'b11111, fuse_ext};
      if (p == 3) return fuse_hi;
      return 8'hFF;
    end
    if (mode == 2) begin
      if (p == 0) return sig1;
      if (p == 1) return cal;
      if (p == 2) return sig2;
      if (p == 4) return sig3;
      return 8'hFF;
    end
    return pm;
  endfunction

  function automatic logic [2:0] ref_ctl(int mode);
    return (mode == 1) ? 3'b011 : (mode == 2) ? 3'b101 : 3'b000;
  endfunction

  task automatic check(string tag, string what, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic step(input logic we, input logic [2:0] wd, input logic ld,
                      input logic [15:0] p, input logic [7:0] pm, input logic spm, input string tag);
    ctl_we = we; ctl_wdata = wd; ld_strobe = ld; ld_ptr = p; pmem_rdata = pm; spm_strobe = spm;
    @(posedge clk);
    e_valid = ld;
    if (ld) e_data = ref_byte(m_mode, p, pm);
    if (we) begin
      m_cnt = 0;
      if (wd[0] && wd[2]) m_mode = 2;
      else if (wd[0] && wd[1]) m_mode = 1;
      else m_mode = 0;
    end else if (m_mode != 0) begin
      if (ld || (spm && m_mode == 1) || m_cnt == 2) m_mode = 0;
      else m_cnt++;
    end
    #2;
    check(tag, "ld_valid", {7'd0, ld_valid}, {7'd0, e_valid});
    if (e_valid) check(tag, "ld_data", ld_data, e_data);
    check(tag, "ctl_q", {5'd0, ctl_q}, {5'd0, ref_ctl(m_mode)});
    @(negedge clk);
    ctl_we = 0; ld_strobe = 0; spm_strobe = 0;
  endtask

  task automatic idle(int n, string tag);
    for (int i = 0; i < n; i++) step(0, 3'b000, 0, 16'h0, 8'h00, 0, tag);
  endtask

  task automatic arm_and_load(logic [2:0] wd, int gap, logic [15:0] p, string tag);
    step(1, wd, 0, 16'h0, 8'h00, 0, tag);
    idle(gap, tag);
    step(0, 3'b000, 1, p, 8'h3C, 0, tag);
  endtask

  initial begin
    #20000000;
    fails++; checks++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #3;
    check("R12", "ctl_q reset", {5'd0, ctl_q}, 8'h00);
    check("R12", "ld_valid reset", {7'd0, ld_valid}, 8'h00);
    check("R12", "ld_data reset", ld_data, 8'h00);
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 R2: idle loads pass program memory through
    step(0, 3'b000, 1, 16'h0000, 8'hA5, 0, "R2");
    step(0, 3'b000, 1, 16'h0003, 8'h17, 0, "R2");
    idle(1, "R1");
    // R3 R4 R6: configuration space, loads at 1st, 2nd, 3rd edge
    arm_and_load(3'b011, 0, 16'h0000, "R3");
    arm_and_load(3'b011, 2, 16'h0003, "R3");
    arm_and_load(3'b011, 1, 16'h0002, "R4");
    arm_and_load(3'b011, 0, 16'h0001, "R4");
    arm_and_load(3'b011, 0, 16'h0005, "R6");
    arm_and_load(3'b011, 0, 16'h8000, "R6");
    // R5 R6: signature space
    arm_and_load(3'b101, 0, 16'h0000, "R5");
    arm_and_load(3'b101, 0, 16'h0001, "R5");
    arm_and_load(3'b101, 2, 16'h0002, "R5");
    arm_and_load(3'b101, 1, 16'h0004, "R5");
    arm_and_load(3'b101, 0, 16'h0003, "R6");
    // R7: load on 4th edge is not redirected
    arm_and_load(3'b011, 3, 16'h0000, "R7");
    arm_and_load(3'b101, 3, 16'h0001, "R7");
    // R8: second load after a redirected one returns program memory
    arm_and_load(3'b011, 0, 16'h0003, "R8");
    step(0, 3'b000, 1, 16'h0003, 8'h77, 0, "R8");
    // R9: store disarms configuration mode; load after returns program memory
    step(1, 3'b011, 0, 16'h0, 8'h00, 0, "R9");
    step(0, 3'b000, 0, 16'h0, 8'h00, 1, "R9");
    step(0, 3'b000, 1, 16'h0000, 8'h66, 0, "R9");
    // R10: rewrite restarts window; enable-low write disarms
    step(1, 3'b011, 0, 16'h0, 8'h00, 0, "R10");
    idle(2, "R10");
    arm_and_load(3'b011, 2, 16'h0003, "R10");
    step(1, 3'b101, 0, 16'h0, 8'h00, 0, "R10");
    step(1, 3'b110, 0, 16'h0, 8'h00, 0, "R10");
    step(0, 3'b000, 1, 16'h0000, 8'h99, 0, "R10");
    // R11: both mode bits, signature wins
    arm_and_load(3'b111, 0, 16'h0000, "R11");
    arm_and_load(3'b111, 0, 16'h0003, "R11");
    // R12: reset while armed
    step(1, 3'b011, 0, 16'h0, 8'h00, 0, "R12");
    rst_n = 1'b0; m_mode = 0; m_cnt = 0;
    #2;
    check("R12", "ctl_q after reset", {5'd0, ctl_q}, 8'h00);
    check("R12", "ld_valid after reset", {7'd0, ld_valid}, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    step(0, 3'b000, 1, 16'h0000, 8'h4B, 0, "R12");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule